// File: doc/BRIEF.md
# Write-Through Store Buffer

This block sits between a write-through data cache and a slow main memory. Every store the processor issues must reach memory. The buffer takes each store's address and data in one cycle, so the processor can move on at once. It then writes the held entries to memory in arrival order, one at a time. Each memory write occupies a fixed, long latency. During that time the buffer keeps taking new stores. The processor is held back only when every slot is taken and the new store cannot join an existing slot.

A store whose address already sits in a slot that is not yet being written to memory joins that slot: its data replaces the older data, and no new slot is used. The slot at the head that is being written cannot change, so a store to that address takes a new slot.

Loads that miss in the cache present their address on a separate lookup port. The block returns the newest held data for that address, so the load never sees stale memory.

The block also tells the cache what to do with each accepted store:
- on a hit, update the line;
- on a miss with allocation, fetch the line and update it;
- on a miss in write-around mode, leave the cache alone, so only the buffered memory write happens.

The drain engine is a three-state machine:
- IDLE: nothing is in flight. Move to ISSUE when the buffer holds an entry.
- ISSUE: a one-cycle write pulse for the head entry. Always move to WAIT.
- WAIT: count down the memory latency. When the count ends, retire the head. Return to ISSUE if more entries remain, otherwise return to IDLE.

Top module: `wt_store_buf`

## Requirements
- R1: After reset the buffer is empty: `buf_empty`=1, `buf_full`=0, `buf_occ`=0, `mem_wr_en`=0, `st_stall`=0.
- R2: A store presented while the buffer is not full is accepted in that cycle without a stall, and occupancy rises by one unless it merges.
- R3: `st_stall` is 1 exactly when `st_valid`=1, the buffer is full, and no mergeable slot matches the address. A store held through a full period gives one unbroken stall run, which ends once a slot frees.
- R4: Entries go to memory in acceptance order. `mem_wr_en` is a one-cycle pulse carrying the head's address and data, and only one write is outstanding at a time.
- R5: A write is issued one cycle after the drain engine leaves IDLE with the buffer non-empty. The head is retired MEM_LAT cycles after its issue cycle. A following write is issued in the next cycle, so consecutive issues are MEM_LAT+1 cycles apart.
- R6: A store to the address of a held entry that is not being written replaces that entry's data and uses no new slot. It is accepted even when the buffer is full.
- R7: A store to the address of the head entry while that entry is being written (from the cycle after the engine leaves IDLE until it retires) takes a new slot.
- R8: `ld_hit`=1 when `ld_addr` matches any held entry, and `ld_data` is the data of the most recently accepted store to that address. Otherwise `ld_hit`=0.
- R9: For an accepted store:
  - `cache_upd` = `st_hit` OR NOT `cfg_around`;
  - `fill_req` = NOT `st_hit` AND NOT `cfg_around`;
  - a stalled store drives both to 0.
- R10: `buf_occ` counts held entries, `buf_full` = (`buf_occ`==DEPTH), and `buf_empty` = (`buf_occ`==0). Occupancy changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store presented by the processor |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_hit | input | 1 | The store hits in the cache |
| cfg_around | input | 1 | 1 selects write-around on a store miss |
| st_stall | output | 1 | Store not accepted this cycle; hold it |
| cache_upd | output | 1 | Write the accepted store into the cache line |
| fill_req | output | 1 | Fetch the missing line (allocate mode) |
| ld_addr | input | AW | Lookup address of a load that missed |
| ld_hit | output | 1 | Lookup address is held in the buffer |
| ld_data | output | DW | Newest held data for the lookup address |
| mem_wr_en | output | 1 | One-cycle memory write pulse |
| mem_wr_addr | output | AW | Memory write address (head entry) |
| mem_wr_data | output | DW | Memory write data (head entry) |
| buf_full | output | 1 | All slots held |
| buf_empty | output | 1 | No slot held |
| buf_occ | output | $clog2(DEPTH)+1 | Number of held entries |

## Verification
Directed bursts of distinct addresses fill the buffer and hold one more store against it. This separates a stall that lasts until the first retirement from a stall that repeats or never comes. A short sequence aimed at the head's address shows that the in-flight head gets a new slot, while a repeated store to a later address merges into its slot. Lookups right after that sequence show that forwarding picks the newest copy. Long random runs over a pool of eight addresses, mixing hits, misses and both miss policies, compare every output each cycle against a bench model. These runs catch wrong drain order, wrong issue spacing, and merges that land in the wrong slot.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        DR_IDLE  = 2'd0,
        DR_ISSUE = 2'd1,
        DR_WAIT  = 2'd2
    } drain_e;
endpackage

// File: rtl/sb_store_array.sv
module sb_store_array
    import sb_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter bit MERGE_EN = 1'b1,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [AW-1:0]    st_addr,
    input  logic [DW-1:0]    st_data,
    input  logic             pop,
    input  logic             lock_head,
    input  logic [AW-1:0]    ld_addr,
    output logic             st_match,
    output logic             ld_hit,
    output logic [DW-1:0]    ld_data,
    output logic [AW-1:0]    head_addr,
    output logic [DW-1:0]    head_data,
    output logic [CNT_W-1:0] count
);
    logic [AW-1:0]    a_q [DEPTH];
    logic [DW-1:0]    d_q [DEPTH];
    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] cnt_q;

    logic [DEPTH-1:0] live, st_hv, ld_hv;
    logic [PTR_W-1:0] st_idx, ld_idx;
    logic             head_ld, merge, push;

    // per-slot liveness and address compare
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [PTR_W-1:0] rel;
        logic             locked;
        assign rel      = PTR_W'(i) - head_q;
        assign live[i]  = CNT_W'(rel) < cnt_q;
        assign locked   = lock_head && (PTR_W'(i) == head_q);
        assign st_hv[i] = MERGE_EN && live[i] && !locked && (a_q[i] == st_addr);
        assign ld_hv[i] = live[i] && !locked && (a_q[i] == ld_addr);
    end

    always_comb begin
        st_idx = '0;
        ld_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_hv[i]) st_idx = PTR_W'(i);
            if (ld_hv[i]) ld_idx = PTR_W'(i);
        end
    end

    // an unlocked match is always newer than the locked head
    assign head_ld  = (cnt_q != '0) && lock_head && (a_q[head_q] == ld_addr);
    assign st_match = |st_hv;
    assign ld_hit   = (|ld_hv) || head_ld;
    assign ld_data  = (|ld_hv) ? d_q[ld_idx] : d_q[head_q];

    assign merge     = accept && st_match;
    assign push      = accept && !st_match;
    assign head_addr = a_q[head_q];
    assign head_data = d_q[head_q];
    assign count     = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) tail_q <= tail_q + PTR_W'(1);
            if (pop)  head_q <= head_q + PTR_W'(1);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (merge) d_q[st_idx] <= st_data;
        if (push) begin
            a_q[tail_q] <= st_addr;
            d_q[tail_q] <= st_data;
        end
    end
endmodule

// File: rtl/sb_drain.sv
module sb_drain
    import sb_pkg::*;
#(
    parameter int MEM_LAT = 100,
    localparam int CW     = $clog2(MEM_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic has_entry,
    input  logic more_entries,
    output logic issue,
    output logic busy,
    output logic retire
);
    drain_e        state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE:  if (has_entry) state_d = DR_ISSUE;
            DR_ISSUE: state_d = DR_WAIT;
            DR_WAIT:  if (cnt_q == '0) state_d = more_entries ? DR_ISSUE : DR_IDLE;
            default:  state_d = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == DR_ISSUE)                    cnt_q <= CW'(MEM_LAT - 1);
            else if (state_q == DR_WAIT && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
        end
    end

    always_comb begin
        issue  = (state_q == DR_ISSUE);
        busy   = (state_q != DR_IDLE);
        retire = (state_q == DR_WAIT) && (cnt_q == '0);
    end
endmodule

// File: rtl/wt_store_buf.sv
module wt_store_buf
    import sb_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int MEM_LAT  = 100,
    parameter bit MERGE_EN = 1'b1,
    localparam int CNT_W   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic [AW-1:0]    st_addr,
    input  logic [DW-1:0]    st_data,
    input  logic             st_hit,
    input  logic             cfg_around,
    output logic             st_stall,
    output logic             cache_upd,
    output logic             fill_req,
    input  logic [AW-1:0]    ld_addr,
    output logic             ld_hit,
    output logic [DW-1:0]    ld_data,
    output logic             mem_wr_en,
    output logic [AW-1:0]    mem_wr_addr,
    output logic [DW-1:0]    mem_wr_data,
    output logic             buf_full,
    output logic             buf_empty,
    output logic [CNT_W-1:0] buf_occ
);
    logic accept, st_match, busy, retire;

    assign buf_full  = (buf_occ == CNT_W'(DEPTH));
    assign buf_empty = (buf_occ == '0);
    assign st_stall  = st_valid && buf_full && !st_match;
    assign accept    = st_valid && !st_stall;
    assign cache_upd = accept && (st_hit || !cfg_around);
    assign fill_req  = accept && !st_hit && !cfg_around;

    sb_store_array #(
        .DEPTH(DEPTH), .AW(AW), .DW(DW), .MERGE_EN(MERGE_EN)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .st_addr(st_addr), .st_data(st_data),
        .pop(retire), .lock_head(busy), .ld_addr(ld_addr),
        .st_match(st_match), .ld_hit(ld_hit), .ld_data(ld_data),
        .head_addr(mem_wr_addr), .head_data(mem_wr_data), .count(buf_occ)
    );

    sb_drain #(.MEM_LAT(MEM_LAT)) u_drain (
        .clk(clk), .rst_n(rst_n),
        .has_entry(buf_occ != '0), .more_entries(buf_occ > CNT_W'(1)),
        .issue(mem_wr_en), .busy(busy), .retire(retire)
    );
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int DEPTH   = 4,
    parameter int MEM_LAT = 100,
    localparam int CNT_W  = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st_valid,
    input logic             st_hit,
    input logic             cfg_around,
    input logic             st_stall,
    input logic             cache_upd,
    input logic             fill_req,
    input logic             mem_wr_en,
    input logic             buf_full,
    input logic             buf_empty,
    input logic [CNT_W-1:0] buf_occ
);
    int unsigned gap;

    always_ff @(posedge clk) begin
        if (!rst_n)                   gap <= MEM_LAT;
        else if (mem_wr_en)           gap <= 0;
        else if (gap < MEM_LAT)       gap <= gap + 1;
    end

    a_r4_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !mem_wr_en);

    a_r5_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> gap >= MEM_LAT);

    a_r3_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> buf_full && st_valid);

    a_r2_accept_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !buf_full) |-> !st_stall);

    a_r9_around_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && cfg_around && !st_hit) |-> !fill_req && !cache_upd);

    a_r9_stalled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> !fill_req && !cache_upd);

    a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(buf_occ) <= int'($past(buf_occ)) + 1) && (int'(buf_occ) + 1 >= int'($past(buf_occ))));

    a_r10_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_full && buf_empty));
endmodule

bind wt_store_buf sb_checker #(.DEPTH(DEPTH), .MEM_LAT(MEM_LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_hit(st_hit),
    .cfg_around(cfg_around), .st_stall(st_stall), .cache_upd(cache_upd),
    .fill_req(fill_req), .mem_wr_en(mem_wr_en), .buf_full(buf_full),
    .buf_empty(buf_empty), .buf_occ(buf_occ)
);

// File: tb/wt_store_buf_tb.sv
module wt_store_buf_tb;
    localparam int DEPTH = 4;
    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int LAT   = 6;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 1'b0, st_hit = 1'b0, cfg_around = 1'b0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic st_stall, cache_upd, fill_req, ld_hit, mem_wr_en, buf_full, buf_empty;
    logic [DW-1:0] ld_data, mem_wr_data;
    logic [AW-1:0] mem_wr_addr;
    logic [CW-1:0] buf_occ;

    always #4 clk = ~clk;

    wt_store_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MEM_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_hit(st_hit), .cfg_around(cfg_around),
        .st_stall(st_stall), .cache_upd(cache_upd), .fill_req(fill_req),
        .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .buf_full(buf_full), .buf_empty(buf_empty), .buf_occ(buf_occ)
    );

    int total = 0, bad = 0;
    bit done = 1'b0;

    // bench model: queue index 0 is the head; ms 0=idle 1=issue 2=wait
    logic [AW-1:0] mqa [DEPTH];
    logic [DW-1:0] mqd [DEPTH];
    int mn = 0, ms = 0, mcnt = 0;
    bit last_stall;

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int find_unl(logic [AW-1:0] a);
        for (int j = 0; j < mn; j++)
            if (!(j == 0 && ms != 0) && mqa[j] == a) return j;
        return -1;
    endfunction

    task automatic step(bit v, logic [AW-1:0] a, logic [DW-1:0] d,
                        bit hit, bit around, logic [AW-1:0] la);
        int mi, li, nst;
        bit es, acc, eh, pop;
        logic [DW-1:0] ed;
        st_valid = v; st_addr = a; st_data = d; st_hit = hit;
        cfg_around = around; ld_addr = la;
        #1;
        mi  = find_unl(a);
        es  = v && (mn == DEPTH) && (mi < 0);
        acc = v && !es;
        chk("R3", st_stall, es);
        chk("R9 cache_upd", cache_upd, acc && (hit || !around));
        chk("R9 fill_req", fill_req, acc && !hit && !around);
        li = find_unl(la);
        eh = (li >= 0) || (mn > 0 && ms != 0 && mqa[0] == la);
        ed = (li >= 0) ? mqd[li] : mqd[0];
        chk("R8 hit", ld_hit, eh);
        if (eh) chk("R8 data", ld_data, ed);
        last_stall = st_stall;
        pop = (ms == 2) && (mcnt == 0);
        nst = ms;
        case (ms)
            0: if (mn > 0) nst = 1;
            1: begin nst = 2; mcnt = LAT - 1; end
            default: if (mcnt == 0) nst = (mn > 1) ? 1 : 0; else mcnt--;
        endcase
        if (acc && mi >= 0) mqd[mi] = d;
        if (pop) begin
            for (int j = 0; j < DEPTH - 1; j++) begin
                mqa[j] = mqa[j+1]; mqd[j] = mqd[j+1];
            end
            mn--;
        end
        if (acc && mi < 0) begin mqa[mn] = a; mqd[mn] = d; mn++; end
        ms = nst;
        @(negedge clk);
        chk("R4 R5 mem_wr_en", mem_wr_en, ms == 1);
        if (ms == 1) begin
            chk("R4 addr", mem_wr_addr, mqa[0]);
            chk("R4 data", mem_wr_data, mqd[0]);
        end
        chk("R2 R10 occ", buf_occ, mn);
        chk("R10 full", buf_full, mn == DEPTH);
        chk("R10 empty", buf_empty, mn == 0);
    endtask

    task automatic idle_until_empty();
        for (int k = 0; k < 200 && !(mn == 0 && ms == 0); k++) step(0, '0, '0, 0, 0, '0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int rises;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 empty", buf_empty, 1'b1);
        chk("R1 full", buf_full, 1'b0);
        chk("R1 occ", buf_occ, '0);
        chk("R1 wr", mem_wr_en, 1'b0);
        chk("R1 stall", st_stall, 1'b0);

        // R2/R3: fill with distinct addresses, then hold one more store
        for (int k = 1; k <= DEPTH; k++) step(1, AW'(k), DW'(k * 17), 1, 0, '0);
        chk("R3 full after burst", buf_full, 1'b1);
        rises = 0;
        begin
            bit prev = 1'b0;
            for (int k = 0; k < 50; k++) begin
                step(1, AW'(16'h55), 32'hABCD, 1, 0, '0);
                if (last_stall && !prev) rises++;
                prev = last_stall;
                if (!last_stall) break;
            end
        end
        chk("R3 one stall run", rises, 1);
        idle_until_empty();

        // R7 then R6: store to head in flight, then merge into a later slot
        step(1, 16'h10, 32'h1, 1, 0, '0);
        step(1, 16'h20, 32'h2, 1, 0, '0);
        step(1, 16'h10, 32'h3, 1, 0, '0);
        chk("R7 new slot for in-flight head", buf_occ, 3);
        step(1, 16'h20, 32'h4, 1, 0, 16'h10);
        chk("R6 merge keeps occupancy", buf_occ, 3);
        step(0, '0, '0, 0, 0, 16'h10);
        chk("R8 newest 0x10", ld_data, 32'h3);
        step(0, '0, '0, 0, 0, 16'h20);
        chk("R8 merged 0x20", ld_data, 32'h4);
        step(0, '0, '0, 0, 0, 16'h77);
        chk("R8 absent", ld_hit, 1'b0);
        idle_until_empty();

        // R9 directed policies
        step(1, 16'h30, 32'h9, 0, 1, '0);
        step(1, 16'h31, 32'h9, 0, 0, '0);
        step(1, 16'h32, 32'h9, 1, 1, '0);
        idle_until_empty();

        // random mix
        for (int k = 0; k < 4000; k++)
            step(($urandom % 2) == 0, AW'($urandom % 8), $urandom,
                 $urandom % 2, $urandom % 2, AW'($urandom % 8));
        idle_until_empty();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule